// File: doc/BRIEF.md
# Self-Refresh Entry/Exit Arbiter

This block decides when a display source may put its panel into self-refresh and when it has to bring it back out. Rendering logic reports which planes it is about to dirty (invalidate) and which planes it has finished writing to memory (flush). Each report carries a plane bitmask. The block keeps a set of busy planes, limited to the planes of the pipe that drives the panel. It drives one-cycle exit and activate requests towards a self-refresh engine, which appears here only as an idle status input.

Re-entry is never immediate. After a flush leaves the busy set empty while self-refresh is off, a re-arm timer starts. When the timer expires, the block waits for the engine to report idle, up to a bounded number of cycles. It then checks again that the feature is still enabled and that no plane has become busy in the meantime. Only then does it issue activate. Enable and disable commands open and close the whole mechanism. The first activation after enable can be deferred by its own delay, for engines that misbehave when activation follows a mode change too closely.

Top module: `selfrefresh_arbiter`

## Requirements
- R1: After reset, sr_enabled, sr_active, act_req and exit_req are 0 and busy_planes is all zeros.
- R2: While sr_enabled is 0, invalidate and flush events leave busy_planes unchanged and raise neither request.
- R3: en_cmd while disabled sets sr_enabled and clears busy_planes in the next cycle. With FIRST_ACT_CYC > 0 and eng_idle high, act_req pulses in the cycle that follows the (FIRST_ACT_CYC+1)-th clock edge after the enable edge. With FIRST_ACT_CYC = 0, activation happens at the enable edge itself.
- R4: Every event mask is ANDed with PLANE_MASK (bit i = plane i). Bits outside PLANE_MASK never enter busy_planes and never cause an exit.
- R5: An invalidate ORs its masked bits into busy_planes. If a masked bit is set while sr_active is 1, exit_req pulses for one cycle and sr_active drops in that same cycle.
- R6: A flush removes its masked bits from busy_planes. If the result is empty and self-refresh is inactive, the re-arm timer starts. With eng_idle high, act_req pulses after the (REARM_CYC+1)-th edge counted from the flush edge.
- R7: A flush whose masked bits are non-zero while sr_active is 1 issues an exit just as an invalidate would, and then re-arms.
- R8: At expiry, activation is skipped if busy_planes is no longer empty. An invalidate during the delay does not stop the timer.
- R9: A flush that re-arms a timer that is already pending reloads the full REARM_CYC delay.
- R10: After expiry, the block waits up to IDLE_LIMIT_CYC edges for eng_idle. Idle seen at the last of those edges still activates. If idle is not seen in that window, the attempt is abandoned and a later rise of eng_idle does nothing.
- R11: dis_cmd clears sr_enabled and cancels any pending timer. If sr_active is 1, it also issues exit_req. dis_cmd takes priority over all other inputs in the same cycle.
- R12: exit_req is only issued while sr_active is 1. act_req and exit_req are single-cycle pulses that set and clear sr_active respectively and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_cmd | input | 1 | One-cycle enable command |
| dis_cmd | input | 1 | One-cycle disable command |
| inv_valid | input | 1 | Invalidate event strobe |
| inv_planes | input | N_PLANES | Planes being dirtied |
| flush_valid | input | 1 | Flush event strobe |
| flush_planes | input | N_PLANES | Planes written back |
| eng_idle | input | 1 | Self-refresh engine reports idle |
| act_req | output | 1 | Activate pulse to engine |
| exit_req | output | 1 | Exit pulse to engine |
| sr_active | output | 1 | Self-refresh currently active |
| sr_enabled | output | 1 | Mechanism enabled |
| busy_planes | output | N_PLANES | Current busy-plane set |

## Verification
A corrupted busy set shows on busy_planes in the cycle after the event. It also shows later as a missing or spurious activate at timer expiry. A timer that counts wrong moves the act_req pulse off its exact expected cycle, so each re-arm check samples the cycle before the pulse and the cycle of the pulse. An idle-wait counter that is off by one is caught by raising eng_idle exactly on the last allowed edge. A stale enable or active flag appears as an exit_req without a preceding activation, or as an activate after disable, both of which show at the ports within a few cycles.

// File: rtl/sra_pkg.sv
// Shared types for the self-refresh arbiter.
package sra_pkg;
    typedef enum logic [1:0] {
        TMR_OFF   = 2'd0,
        TMR_DELAY = 2'd1,
        TMR_WAIT  = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/sra_plane_tracker.sv
// Busy-plane set. Masks incoming event bitmasks to the panel pipe's planes,
// ORs invalidated planes in and removes flushed planes. Assumes the caller
// gates 'accept' with the enabled state; 'clear' wins over events.
module sra_plane_tracker #(
    parameter int unsigned          N_PLANES   = 8,
    parameter logic [N_PLANES-1:0]  PLANE_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                accept,
    input  logic                inv_valid,
    input  logic [N_PLANES-1:0] inv_planes,
    input  logic                flush_valid,
    input  logic [N_PLANES-1:0] flush_planes,
    output logic [N_PLANES-1:0] busy_q,
    output logic [N_PLANES-1:0] busy_d,
    output logic                hit
);
    logic [N_PLANES-1:0] inv_m, fl_m;

    // Restrict event masks to the planes of the panel pipe
    always_comb begin
        inv_m = (accept && inv_valid)   ? (inv_planes   & PLANE_MASK) : '0;
        fl_m  = (accept && flush_valid) ? (flush_planes & PLANE_MASK) : '0;
        hit   = (|inv_m) || (|fl_m);
        if (clear)
            busy_d = '0;
        else
            busy_d = (busy_q | inv_m) & ~fl_m;
    end

    // Hold the busy-plane set
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end
endmodule

// File: rtl/sra_rearm_timer.sv
// Re-arm timer: counts a loaded delay down, then waits a bounded number of
// edges for the engine idle status. 'try_act' is high in the wait phase
// when idle is seen; the caller decides whether to activate. Cancel has
// priority over start, start (reload) over normal counting.
module sra_rearm_timer
    import sra_pkg::*;
#(
    parameter int unsigned CW         = 8,
    parameter int unsigned IDLE_LIMIT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    input  logic          cancel,
    input  logic          eng_idle,
    output logic          try_act
);
    localparam int unsigned WW = $clog2(IDLE_LIMIT + 1);

    tmr_state_t    st;
    logic [CW-1:0] cnt;
    logic [WW-1:0] wcnt;

    // Idle seen during the wait phase, unless overridden this cycle
    assign try_act = (st == TMR_WAIT) && eng_idle && !cancel && !start;

    // Delay countdown and idle-wait window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= TMR_OFF;
            cnt  <= '0;
            wcnt <= '0;
        end else if (cancel) begin
            st <= TMR_OFF;
        end else if (start) begin
            st  <= TMR_DELAY;
            cnt <= load;
        end else begin
            case (st)
                TMR_DELAY: begin
                    if (cnt <= CW'(1)) begin
                        st   <= TMR_WAIT;
                        wcnt <= '0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                TMR_WAIT: begin
                    if (eng_idle || wcnt == WW'(IDLE_LIMIT - 1))
                        st <= TMR_OFF;
                    else
                        wcnt <= wcnt + WW'(1);
                end
                default: st <= TMR_OFF;
            endcase
        end
    end
endmodule

// File: rtl/selfrefresh_arbiter.sv
// Self-refresh arbiter top. Tracks dirty planes from invalidate/flush
// events, forces exits while active, and re-activates through a deferred
// timer that rechecks enable and the busy set at expiry. Assumes commands
// and events are single-cycle strobes; dis_cmd dominates.
module selfrefresh_arbiter #(
    parameter int unsigned          N_PLANES       = 8,
    parameter logic [N_PLANES-1:0]  PLANE_MASK     = 8'h0F,
    parameter int unsigned          REARM_CYC      = 5000000,
    parameter int unsigned          IDLE_LIMIT_CYC = 2500000,
    parameter int unsigned          FIRST_ACT_CYC  = 10000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_cmd,
    input  logic                dis_cmd,
    input  logic                inv_valid,
    input  logic [N_PLANES-1:0] inv_planes,
    input  logic                flush_valid,
    input  logic [N_PLANES-1:0] flush_planes,
    input  logic                eng_idle,
    output logic                act_req,
    output logic                exit_req,
    output logic                sr_active,
    output logic                sr_enabled,
    output logic [N_PLANES-1:0] busy_planes
);
    localparam int unsigned MAXD  = (REARM_CYC > FIRST_ACT_CYC) ? REARM_CYC : FIRST_ACT_CYC;
    localparam int unsigned CW    = $clog2(MAXD + 2);
    localparam bit          DEFER = (FIRST_ACT_CYC != 0);

    logic [N_PLANES-1:0] busy_d;
    logic                hit, accept, clear, exit_now, active_after;
    logic                rearm, first_arm, tmr_start, try_act, act_now;
    logic [CW-1:0]       tmr_load;

    // Decide this cycle's exit, re-arm and activation
    always_comb begin
        accept       = sr_enabled && !dis_cmd;
        clear        = !sr_enabled && en_cmd && !dis_cmd;
        exit_now     = sr_enabled && sr_active && (hit || dis_cmd);
        active_after = sr_active && !exit_now;
        rearm        = accept && flush_valid && !active_after && (busy_d == '0);
        first_arm    = DEFER && clear;
        tmr_start    = rearm || first_arm;
        tmr_load     = first_arm ? CW'(FIRST_ACT_CYC) : CW'(REARM_CYC);
        act_now      = (try_act && accept && !active_after && (busy_d == '0))
                     || (!DEFER && clear);
    end

    sra_plane_tracker #(.N_PLANES(N_PLANES), .PLANE_MASK(PLANE_MASK)) u_track (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept),
        .inv_valid(inv_valid), .inv_planes(inv_planes),
        .flush_valid(flush_valid), .flush_planes(flush_planes),
        .busy_q(busy_planes), .busy_d(busy_d), .hit(hit)
    );

    sra_rearm_timer #(.CW(CW), .IDLE_LIMIT(IDLE_LIMIT_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load),
        .cancel(dis_cmd), .eng_idle(eng_idle), .try_act(try_act)
    );

    // Enabled/active flags and registered request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_enabled <= 1'b0;
            sr_active  <= 1'b0;
            act_req    <= 1'b0;
            exit_req   <= 1'b0;
        end else begin
            if (dis_cmd)    sr_enabled <= 1'b0;
            else if (clear) sr_enabled <= 1'b1;
            sr_active <= (active_after || act_now) && !dis_cmd;
            act_req   <= act_now;
            exit_req  <= exit_now;
        end
    end
endmodule

// File: rtl/sra_checker.sv
// Port-level properties of the self-refresh arbiter, bound to every instance.
module sra_checker #(
    parameter int unsigned          N_PLANES   = 8,
    parameter logic [N_PLANES-1:0]  PLANE_MASK = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_cmd,
    input logic                dis_cmd,
    input logic                act_req,
    input logic                exit_req,
    input logic                sr_active,
    input logic                sr_enabled,
    input logic [N_PLANES-1:0] busy_planes
);
    p_mask_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_planes & ~PLANE_MASK) == '0);

    p_frozen_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_enabled && !en_cmd) |=> $stable(busy_planes));

    p_enable_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_enabled) |-> busy_planes == '0);

    p_act_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_req |-> busy_planes == '0);

    p_exit_from_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> ($past(sr_active) && !sr_active));

    p_act_sets_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
        act_req |-> (sr_active && sr_enabled && !exit_req));

    p_disable_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd |=> (!sr_enabled && !sr_active));
endmodule

bind selfrefresh_arbiter sra_checker #(.N_PLANES(N_PLANES), .PLANE_MASK(PLANE_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .act_req(act_req), .exit_req(exit_req), .sr_active(sr_active),
    .sr_enabled(sr_enabled), .busy_planes(busy_planes)
);

// File: tb/tb_selfrefresh_arbiter.sv
`timescale 1ns/1ps
module tb_selfrefresh_arbiter;
    localparam int N  = 8;
    localparam logic [7:0] PM = 8'h35;
    localparam int RA = 20;
    localparam int IL = 10;
    localparam int FA = 40;

    logic clk = 0, rst_n = 0;
    logic en_cmd = 0, dis_cmd = 0, inv_valid = 0, flush_valid = 0, eng_idle = 1;
    logic [N-1:0] inv_planes = '0, flush_planes = '0;
    logic act_req, exit_req, sr_active, sr_enabled;
    logic [N-1:0] busy_planes;
    int nchk = 0, nfail = 0, act_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    selfrefresh_arbiter #(.N_PLANES(N), .PLANE_MASK(PM), .REARM_CYC(RA),
        .IDLE_LIMIT_CYC(IL), .FIRST_ACT_CYC(FA)) dut (
        .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .inv_valid(inv_valid), .inv_planes(inv_planes),
        .flush_valid(flush_valid), .flush_planes(flush_planes),
        .eng_idle(eng_idle), .act_req(act_req), .exit_req(exit_req),
        .sr_active(sr_active), .sr_enabled(sr_enabled), .busy_planes(busy_planes));

    always @(negedge clk) if (act_req) act_seen++;

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic inv(input logic [7:0] m);
        inv_valid = 1; inv_planes = m; step(); inv_valid = 0; inv_planes = '0;
    endtask

    task automatic flush(input logic [7:0] m);
        flush_valid = 1; flush_planes = m; step(); flush_valid = 0; flush_planes = '0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic t_reset;
        step(3); rst_n = 1;
        chk("R1 enabled", sr_enabled, 0); chk("R1 active", sr_active, 0);
        chk("R1 busy", busy_planes, 0);  chk("R1 reqs", {act_req, exit_req}, 0);
    endtask

    task automatic t_disabled_ignored;
        inv(8'hFF);   chk("R2 busy after inv", busy_planes, 0);
        flush(8'hFF); chk("R2 busy after flush", busy_planes, 0);
        step(RA + IL + 2);
        chk("R2 no act", act_seen, 0); chk("R2 still disabled", sr_enabled, 0);
    endtask

    task automatic t_enable_first;
        en_cmd = 1; step(); en_cmd = 0;
        chk("R3 enabled", sr_enabled, 1); chk("R3 busy cleared", busy_planes, 0);
        step(FA); chk("R3 not yet active", sr_active, 0);
        step();   chk("R3 act pulse", act_req, 1); chk("R12 active set", sr_active, 1);
        step();   chk("R12 act one cycle", act_req, 0);
    endtask

    task automatic t_mask;
        inv(8'hCA);   chk("R4 inv outside mask busy", busy_planes, 0);
        chk("R4 no exit", exit_req, 0); chk("R4 still active", sr_active, 1);
        flush(8'hCA); chk("R4 flush outside mask", sr_active, 1);
    endtask

    task automatic t_invalidate;
        inv(8'h0F);
        chk("R5 busy or", busy_planes, 8'h05); chk("R5 exit pulse", exit_req, 1);
        chk("R5 active dropped", sr_active, 0);
        step(); chk("R12 exit one cycle", exit_req, 0);
        inv(8'h01); chk("R12 no exit while inactive", exit_req, 0);
    endtask

    task automatic t_flush_rearm;
        int a0;
        flush(8'h01); chk("R6 partial flush", busy_planes, 8'h04);
        a0 = act_seen; step(RA + 5); chk("R6 no rearm while busy", act_seen, a0);
        flush(8'h04); chk("R6 busy empty", busy_planes, 0);
        step(RA); chk("R6 not before expiry", sr_active, 0);
        step();   chk("R6 act at expiry", act_req, 1);
    endtask

    task automatic t_flush_exit;
        flush(8'h10);
        chk("R7 flush exit", exit_req, 1); chk("R7 inactive", sr_active, 0);
        step(RA + 1); chk("R7 rearmed", sr_active, 1);
    endtask

    task automatic t_recheck;
        int a0;
        inv(8'h10); flush(8'h10);
        step(5); inv(8'h20);
        a0 = act_seen; step(RA + IL + 5);
        chk("R8 skipped", act_seen, a0); chk("R8 busy kept", busy_planes, 8'h20);
        flush(8'h20); step(RA + 1); chk("R8 later act", sr_active, 1);
    endtask

    task automatic t_restart;
        inv(8'h01); flush(8'h01);
        step(10); flush(8'h01);
        step(RA); chk("R9 reloaded", sr_active, 0);
        step();   chk("R9 act after reload", act_req, 1);
    endtask

    task automatic t_idle_wait;
        int a0;
        eng_idle = 0; inv(8'h01); flush(8'h01);
        step(RA + IL - 1); chk("R10 waiting", sr_active, 0);
        eng_idle = 1; step(); chk("R10 idle on last edge", act_req, 1);
        eng_idle = 0; inv(8'h01); flush(8'h01);
        step(RA + IL); eng_idle = 1;
        a0 = act_seen; step(5);
        chk("R10 abandoned", act_seen, a0); chk("R10 inactive", sr_active, 0);
    endtask

    task automatic t_disable;
        int a0;
        flush(8'h01); step(5);
        dis_cmd = 1; step(); dis_cmd = 0;
        chk("R11 disabled", sr_enabled, 0);
        a0 = act_seen; step(RA + IL + 5); chk("R11 timer cancelled", act_seen, a0);
        en_cmd = 1; step(); en_cmd = 0; step(FA + 1);
        chk("R11 reactivated", sr_active, 1);
        dis_cmd = 1; step(); dis_cmd = 0;
        chk("R11 exit on disable", exit_req, 1); chk("R11 inactive", sr_active, 0);
        inv(8'h05); chk("R2 ignored after disable", busy_planes, 0);
    endtask

    initial begin
        t_reset; t_disabled_ignored; t_enable_first; t_mask; t_invalidate;
        t_flush_rearm; t_flush_exit; t_recheck; t_restart; t_idle_wait; t_disable;
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report;
    end
endmodule